// File: doc/BRIEF.md
# Mode-Banked Register File with Two Read Ports

This block holds the architectural integer registers of a small processor core. It has sixteen register names and two read ports that return data combinationally. A single write port updates storage on the rising clock edge when its enable is high. A 3-bit operating-mode input decides which physical word a name reaches. The low names and the top name are common to every mode. The fast-interrupt mode has its own copies of names 8 to 14. Each of the other exception modes has its own copies of names 13 and 14, the stack pointer and the link register.

Behind the sixteen names sit 31 physical words. There are sixteen common words, seven fast-interrupt words, and two words for each of the normal-interrupt, supervisor, abort and undefined modes. A name-to-slot mapper is shared by all three ports. A read does not disturb storage. A read of the slot being written in the same cycle returns the old contents.

Top module: `rfb_regfile`

## Requirements
- R1: A synchronous active-high reset sets every physical word to zero, so every name reads 0 in every mode afterwards.
- R2: While `wr_en` is 0, no stored word changes, whatever `wr_idx`, `wr_data` and `mode` carry.
- R3: A write lands at the clock edge. A read of the same physical word in the write cycle returns the old value, and the new value is returned from the next cycle on.
- R4: Names 0 to 7 reach the same physical word in every mode.
- R5: In mode 1 (fast interrupt), names 8 to 12 reach words private to that mode. In every other mode, names 8 to 12 reach one shared word set.
- R6: Name 13 reaches a separate word for each of mode 1, mode 2 (normal interrupt), mode 3 (supervisor), mode 4 (abort) and mode 5 (undefined). Mode 0 (user/system) has one further word of its own.
- R7: Name 14 is banked in exactly the same way as name 13, with separate words.
- R8: Name 15 reaches one word that is common to all modes.
- R9: The two read ports select independently and may read while a write takes place. Repeated reads return the same value.
- R10: Mode codes 6 and 7 are handled exactly like code 0 (user/system).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Operating mode: 0 user/system, 1 fast irq, 2 irq, 3 supervisor, 4 abort, 5 undefined, 6/7 as 0 |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Register name to write |
| wr_data | input | DATA_W | Value to write |
| rd_idx_a | input | 4 | Register name for read port A |
| rd_data_a | output | DATA_W | Read port A value |
| rd_idx_b | input | 4 | Register name for read port B |
| rd_data_b | output | DATA_W | Read port B value |

## Verification
A write and a read of the same physical word can fall into one cycle, and so can a write in one bank and a read of the same name in another bank. The bench drives a write together with both read ports on the written name in that cycle, and it expects the old contents there. It expects the new contents one cycle later. Randomly chosen cycles also mix writes and reads across all eight mode codes. A scoreboard holds a bank-aware model, checks each read against it before the write lands, and applies the write only afterwards.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

    localparam int ARCH_REGS  = 16;
    localparam int IDX_W      = $clog2(ARCH_REGS);
    localparam int SHARED_LO  = 8;            // names below this never bank
    localparam int FIQ_FIRST  = 8;            // first name banked in fast irq
    localparam int SP_NAME    = 13;
    localparam int LR_NAME    = 14;
    localparam int FIQ_WORDS  = LR_NAME - FIQ_FIRST + 1;
    localparam int EXC_MODES  = 4;
    localparam int EXC_WORDS  = 2;
    localparam int PHYS_REGS  = ARCH_REGS + FIQ_WORDS + EXC_MODES * EXC_WORDS;
    localparam int PHYS_W     = $clog2(PHYS_REGS);
    localparam int FIQ_BASE   = ARCH_REGS;
    localparam int EXC_BASE   = FIQ_BASE + FIQ_WORDS;

    typedef enum logic [2:0] {
        MODE_USR  = 3'd0,
        MODE_FIQ  = 3'd1,
        MODE_IRQ  = 3'd2,
        MODE_SVC  = 3'd3,
        MODE_ABT  = 3'd4,
        MODE_UND  = 3'd5,
        MODE_RES6 = 3'd6,
        MODE_RES7 = 3'd7
    } opmode_e;

    typedef logic [IDX_W-1:0]  arch_idx_t;
    typedef logic [PHYS_W-1:0] phys_idx_t;

    typedef struct packed {
        logic      en;
        phys_idx_t slot;
    } wr_slot_t;

    // Exception bank ordinal 0..3 for modes that own a private SP/LR pair.
    function automatic int exc_ordinal(opmode_e m);
        case (m)
            MODE_IRQ: return 0;
            MODE_SVC: return 1;
            MODE_ABT: return 2;
            MODE_UND: return 3;
            default:  return -1;
        endcase
    endfunction

    // Translate a register name under a mode into a physical slot.
    function automatic phys_idx_t map_name(opmode_e m, arch_idx_t r);
        int ri;
        int ord;
        int slot;
        ri   = int'(r);
        ord  = exc_ordinal(m);
        slot = ri;
        if (ri >= SHARED_LO && ri <= LR_NAME) begin
            if (m == MODE_FIQ) begin
                slot = FIQ_BASE + (ri - FIQ_FIRST);
            end else if (ri >= SP_NAME && ord >= 0) begin
                slot = EXC_BASE + ord * EXC_WORDS + (ri - SP_NAME);
            end
        end
        return phys_idx_t'(slot);
    endfunction

endpackage

// File: rtl/rfb_name_map.sv
module rfb_name_map
    import rfb_pkg::*;
#(
    parameter int N_PORTS = 2
) (
    input  opmode_e   mode,
    input  arch_idx_t idx  [N_PORTS],
    output phys_idx_t slot [N_PORTS]
);

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        always_comb begin
            slot[p] = map_name(mode, idx[p]);
        end
    end

endmodule

// File: rtl/rfb_store.sv
module rfb_store
    import rfb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = PHYS_REGS,
    parameter int N_RD   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_slot_t          wr,
    input  logic [DATA_W-1:0] wr_data,
    input  phys_idx_t         rd_slot [N_RD],
    output logic [DATA_W-1:0] rd_data [N_RD]
);

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        localparam phys_idx_t MY_SLOT = phys_idx_t'(w);
        always_ff @(posedge clk) begin
            if (rst) begin
                words[w] <= '0;
            end else if (wr.en && wr.slot == MY_SLOT) begin
                words[w] <= wr_data;
            end
        end
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        always_comb begin
            rd_data[p] = '0;
            if (int'(rd_slot[p]) < DEPTH) begin
                rd_data[p] = words[rd_slot[p]];
            end
        end
    end

endmodule

// File: rtl/rfb_regfile.sv
module rfb_regfile
    import rfb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [3:0]        rd_idx_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [3:0]        rd_idx_b,
    output logic [DATA_W-1:0] rd_data_b
);

    localparam int N_RD = 2;
    localparam int N_MAP = N_RD + 1;

    opmode_e           cur_mode;
    arch_idx_t         name_vec [N_MAP];
    phys_idx_t         slot_vec [N_MAP];
    phys_idx_t         rd_slot  [N_RD];
    logic [DATA_W-1:0] rd_vec   [N_RD];
    wr_slot_t          wr_req;

    assign cur_mode    = opmode_e'(mode);
    assign name_vec[0] = rd_idx_a;
    assign name_vec[1] = rd_idx_b;
    assign name_vec[2] = wr_idx;

    rfb_name_map #(.N_PORTS(N_MAP)) u_map (
        .mode (cur_mode),
        .idx  (name_vec),
        .slot (slot_vec)
    );

    for (genvar p = 0; p < N_RD; p++) begin : g_rsel
        assign rd_slot[p] = slot_vec[p];
    end

    assign wr_req.en   = wr_en;
    assign wr_req.slot = slot_vec[N_RD];

    rfb_store #(.DATA_W(DATA_W), .DEPTH(PHYS_REGS), .N_RD(N_RD)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_req),
        .wr_data (wr_data),
        .rd_slot (rd_slot),
        .rd_data (rd_vec)
    );

    assign rd_data_a = rd_vec[0];
    assign rd_data_b = rd_vec[1];

endmodule

// File: rtl/rfb_regfile_chk.sv
module rfb_regfile_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        mode,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [3:0]        rd_idx_a,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [3:0]        rd_idx_b,
    input logic [DATA_W-1:0] rd_data_b
);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data_a == '0 && rd_data_b == '0)); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && $stable(mode) && $stable(rd_idx_a))
        |-> $stable(rd_data_a)); // R2

    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && mode == $past(mode) && rd_idx_a == $past(wr_idx))
        |-> rd_data_a == $past(wr_data)); // R3

    AST_LOW_COMMON: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && $past(wr_idx) < 4'd8 && rd_idx_b == $past(wr_idx))
        |-> rd_data_b == $past(wr_data)); // R4

    AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_a == rd_idx_b) |-> rd_data_a == rd_data_b); // R9

endmodule

bind rfb_regfile rfb_regfile_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/rfb_regfile_test.sv
`timescale 1ns/1ps
module rfb_regfile_test;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b0;
    logic [2:0]    mode = '0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic [3:0]    rd_idx_a = '0;
    logic [3:0]    rd_idx_b = '0;
    logic [DW-1:0] rd_data_a;
    logic [DW-1:0] rd_data_b;

    always #5 clk = ~clk;

    rfb_regfile #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .mode(mode), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
        .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b)
    );

    typedef struct {
        logic [DW-1:0] exp_a;
        logic [DW-1:0] exp_b;
        string         tag;
    } item_t;

    item_t         sb_q [$];
    logic [DW-1:0] model [int];
    int            total = 0;
    int            bad   = 0;
    bit            finished = 0;
    event          sample_ev;

    // Bank key derived from the requirements: which copy a name reaches.
    function automatic int bank_key(logic [2:0] m, logic [3:0] r);
        int eff;
        eff = (m > 3'd5) ? 0 : int'(m);
        if (r < 4'd8 || r == 4'd15) return int'(r);
        if (eff == 1) return 100 + int'(r);
        if (r >= 4'd13 && eff >= 2) return eff * 100 + int'(r);
        return int'(r);
    endfunction

    function automatic logic [DW-1:0] mread(logic [2:0] m, logic [3:0] r);
        int k;
        k = bank_key(m, r);
        if (model.exists(k)) return model[k];
        return '0;
    endfunction

    task automatic cyc(input logic [2:0] m, input logic we, input logic [3:0] wi,
                       input logic [DW-1:0] wd, input logic [3:0] ra,
                       input logic [3:0] rb, input string tag);
        item_t it;
        @(negedge clk);
        mode = m; wr_en = we; wr_idx = wi; wr_data = wd;
        rd_idx_a = ra; rd_idx_b = rb;
        it.exp_a = mread(m, ra);
        it.exp_b = mread(m, rb);
        it.tag   = tag;
        sb_q.push_back(it);
        #1 -> sample_ev;
        @(posedge clk);
        if (we) model[bank_key(m, wi)] = wd;
    endtask

    task automatic rd(input logic [2:0] m, input logic [3:0] ra,
                      input logic [3:0] rb, input string tag);
        cyc(m, 1'b0, 4'd0, 32'hDEAD_0000, ra, rb, tag);
    endtask

    task automatic wr(input logic [2:0] m, input logic [3:0] wi,
                      input logic [DW-1:0] wd, input string tag);
        cyc(m, 1'b1, wi, wd, wi, wi, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model.delete();
    endtask

    // Monitor: compare outputs against the queued expectation.
    initial begin
        item_t it;
        forever begin
            @(sample_ev);
            it = sb_q.pop_front();
            total++;
            if (rd_data_a !== it.exp_a) begin
                bad++;
                $display("FAIL %s port A: actual=%h expected=%h", it.tag, rd_data_a, it.exp_a);
            end else if (rd_data_b !== it.exp_b) begin
                bad++;
                $display("FAIL %s port B: actual=%h expected=%h", it.tag, rd_data_b, it.exp_b);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: everything zero after reset, in two modes
        for (int r = 0; r < 16; r++) rd(3'd0, 4'(r), 4'(15 - r), "R1");
        for (int r = 8; r < 15; r++) rd(3'd1, 4'(r), 4'(r), "R1");

        // R4: low names common to all modes
        wr(3'd0, 4'd3, 32'h0000_0303, "R4");
        wr(3'd1, 4'd5, 32'h0000_0505, "R4");
        for (int m = 0; m < 8; m++) rd(3'(m), 4'd3, 4'd5, "R4");

        // R5: fast irq private names 8..12, shared elsewhere
        wr(3'd0, 4'd10, 32'hAAAA_0010, "R5");
        wr(3'd1, 4'd10, 32'hBBBB_0010, "R5");
        wr(3'd3, 4'd12, 32'hCCCC_0012, "R5");
        rd(3'd0, 4'd10, 4'd12, "R5");
        rd(3'd1, 4'd10, 4'd12, "R5");
        rd(3'd2, 4'd10, 4'd12, "R5");
        rd(3'd5, 4'd12, 4'd10, "R5");

        // R6/R7: per-mode stack pointer and link register
        for (int m = 0; m < 6; m++) wr(3'(m), 4'd13, 32'h5000_0000 + m, "R6");
        for (int m = 0; m < 6; m++) wr(3'(m), 4'd14, 32'h7000_0000 + m, "R7");
        for (int m = 0; m < 6; m++) rd(3'(m), 4'd13, 4'd14, "R6");
        for (int m = 5; m >= 0; m--) rd(3'(m), 4'd14, 4'd13, "R7");

        // R10: codes 6 and 7 behave as user
        wr(3'd7, 4'd13, 32'h7777_0013, "R10");
        rd(3'd0, 4'd13, 4'd14, "R10");
        rd(3'd6, 4'd13, 4'd11, "R10");
        rd(3'd2, 4'd13, 4'd14, "R10");

        // R8: name 15 common to all modes
        wr(3'd1, 4'd15, 32'h1515_1515, "R8");
        for (int m = 0; m < 8; m++) rd(3'(m), 4'd15, 4'd3, "R8");

        // R2: disabled write has no effect
        cyc(3'd3, 1'b0, 4'd13, 32'hFFFF_FFFF, 4'd13, 4'd3, "R2");
        cyc(3'd1, 1'b0, 4'd3, 32'hFFFF_FFFF, 4'd3, 4'd13, "R2");
        rd(3'd3, 4'd13, 4'd3, "R2");

        // R3: same-cycle read returns old value, next cycle new
        cyc(3'd4, 1'b1, 4'd13, 32'h0BAD_F00D, 4'd13, 4'd13, "R3");
        rd(3'd4, 4'd13, 4'd14, "R3");
        cyc(3'd0, 1'b1, 4'd2, 32'h2222_2222, 4'd2, 4'd2, "R3");
        rd(3'd1, 4'd2, 4'd13, "R3");

        // R9: independent ports, reads repeatable, read during write
        cyc(3'd2, 1'b1, 4'd9, 32'h0909_0909, 4'd13, 4'd14, "R9");
        rd(3'd2, 4'd9, 4'd13, "R9");
        rd(3'd2, 4'd9, 4'd13, "R9");

        // Random mixed traffic over all modes
        for (int i = 0; i < 600; i++) begin
            cyc(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                4'($urandom_range(0, 15)), $urandom,
                4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), "R9");
        end

        // R1: reset after traffic clears all banks
        do_reset();
        for (int m = 0; m < 6; m++) rd(3'(m), 4'd13, 4'd14, "R1");
        rd(3'd1, 4'd10, 4'd15, "R1");

        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule